// File: doc/BRIEF.md
# Period-Tracking 50% Duty Regenerator

This block takes a digital input of any duty cycle and drives a square wave at the same frequency with a duty cycle of one half. A 16-bit down-counter, paced by a selectable prescaler, times the input. On every rising edge of the synchronised input the counter is captured and restarted at all ones. Because the restart value is all ones, the number of ticks since the previous edge is the bitwise inverse of the captured value, and no subtractor is needed.

On the same edge the block loads a compare register with the midpoint of the period that just ended and drives the output high. The output goes low again when the counter has counted down through half of that period. The capture, the period register and the compare register are all updated together in one clock cycle. If the input stops, the counter stops at zero. The output is then held low and a timeout flag is raised until the input resumes.

Top module: `period_regen`

## Requirements
- R1: While reset is asserted, and right after it is released, `sq_o` is 0, `period_o` is 0 and `timeout_o` is 0.
- R2: `psc_sel_i` sets the tick rate: 2'b00 gives no ticks (the counter never moves and every period measures 0), 2'b01 gives one tick per clock, 2'b10 one tick every 4 clocks, and 2'b11 one tick every 16 clocks.
- R3: `sig_i` passes through a two-stage synchroniser. Only its rising edges are active, so a change in the input duty cycle at a constant period leaves `period_o` and the output high time unchanged.
- R4: On each valid rising edge, `period_o` takes the number of ticks since the previous rising edge. That value equals 16'hFFFF minus the count captured at the edge, and the counter then restarts at 16'hFFFF.
- R5: `sq_o` rises only on a rising edge that completes a valid measurement. The first rising edge after reset leaves `sq_o` low.
- R6: After a valid edge that measured P ticks, `sq_o` falls on the floor(P/2)-th tick after that edge. With one tick per clock it therefore stays high for exactly floor(P/2) clocks.
- R7: When the counter reaches zero before the next rising edge, it stays at zero, `timeout_o` goes to 1 and `sq_o` is held at 0. The next rising edge clears `timeout_o` and restarts the count without raising `sq_o`, and the edge after that is valid again.
- R8: `period_o` and the midpoint compare value change only in a cycle that has a valid capture, and both change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_sel_i | input | 2 | Tick rate select: 00 off, 01 /1, 10 /4, 11 /16 |
| sig_i | input | 1 | Input signal, may be asynchronous |
| sq_o | output | 1 | Regenerated 50% duty output |
| period_o | output | 16 | Last measured period, in ticks |
| timeout_o | output | 1 | Counter reached zero with no edge |

## Verification
The assertions assume two things about the input. A synchronised rising edge is never followed by another in the next cycle, which means each high and low phase of `sig_i` lasts at least one clock. The tick select is also assumed not to change in the middle of a measurement, so that the midpoint check sees a steady decrement. The stimulus drives `sig_i` only on falling clock edges and keeps every phase at least one clock long. It changes `psc_sel_i` only while reset is held, and it uses periods that are whole multiples of the tick ratio, so the expected period count and high time follow directly from R2, R4 and R6.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  typedef enum logic [1:0] {
    PSC_OFF   = 2'b00,
    PSC_DIV1  = 2'b01,
    PSC_DIVM  = 2'b10,
    PSC_DIVS  = 2'b11
  } psc_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } meas_st_e;
endpackage

// File: rtl/rgn_prescale.sv
module rgn_prescale
  import rgn_pkg::*;
#(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int PW = $clog2(DIV_SLOW);

  psc_sel_e        psel;
  logic [PW-1:0]   pre_q, pre_d, lim;
  logic            en;

  assign psel = psc_sel_e'(sel_i);

  always_comb begin
    en  = 1'b1;
    lim = '0;
    case (psel)
      PSC_OFF:  begin en = 1'b0; lim = '0; end
      PSC_DIV1: lim = '0;
      PSC_DIVM: lim = PW'(DIV_MID - 1);
      PSC_DIVS: lim = PW'(DIV_SLOW - 1);
      default:  begin en = 1'b0; lim = '0; end
    endcase
  end

  assign tick_o = en && (pre_q >= lim);

  always_comb begin
    if (!en || tick_o) pre_d = '0;
    else               pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == PSC_OFF) |=> (!tick_o || psel != PSC_OFF)); // R2

  AST_SLOW_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psel != PSC_DIV1) |=> (!tick_o || psel == PSC_DIV1)); // R2
endmodule

// File: rtl/rgn_edge_det.sv
module rgn_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic [SYNC:0] sh_q, sh_d;

  always_comb begin
    sh_d[0] = sig_i;
    for (int i = 1; i <= SYNC; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[SYNC-1] & ~sh_q[SYNC];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/rgn_period_timer.sv
module rgn_period_timer
  import rgn_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rise_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] half_o,
  output logic          cap_vld_o,
  output logic          tmo_hit_o,
  output logic          timeout_o,
  output logic [CW-1:0] period_o
);
  meas_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, dec, elapsed, per_q, per_d;
  logic          to_q, to_d;

  // value the counter would hold after this cycle's tick
  always_comb begin
    if (tick_i && cnt_q != '0) dec = cnt_q - CW'(1);
    else                       dec = cnt_q;
  end

  assign elapsed   = ~dec;
  assign half_o    = elapsed >> 1;
  assign cap_vld_o = rise_i && (st_q == ST_MEAS) && !to_q;
  assign tmo_hit_o = !rise_i && (st_q == ST_MEAS) && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    st_d  = st_q;
    to_d  = to_q;
    per_d = per_q;
    if (rise_i) begin
      cnt_d = '1;
      st_d  = ST_MEAS;
      to_d  = 1'b0;
    end else begin
      if (st_q == ST_MEAS) cnt_d = dec;
      if (tmo_hit_o)       to_d  = 1'b1;
    end
    if (cap_vld_o) per_d = elapsed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      st_q  <= ST_IDLE;
      to_q  <= 1'b0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
      to_q  <= to_d;
      per_q <= per_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign timeout_o = to_q;
  assign period_o  = per_q;

  AST_RELOAD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (cnt_q == '1)); // R4

  AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !rise_i) |=> (cnt_q == '0 && to_q)); // R7

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld_o |=> $stable(per_q)); // R8
endmodule

// File: rtl/rgn_duty_gen.sv
module rgn_duty_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rise_i,
  input  logic          cap_vld_i,
  input  logic          tmo_hit_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] half_i,
  output logic          sq_o
);
  logic [CW-1:0] cmp_q, cmp_d;
  logic          arm_q, arm_d, sq_q, sq_d, hit;

  // falls on the tick that decrements the counter onto the midpoint
  assign hit = arm_q && tick_i && (cnt_i == cmp_q + CW'(1));

  always_comb begin
    cmp_d = cmp_q;
    arm_d = arm_q;
    sq_d  = sq_q;
    if (cap_vld_i) begin
      cmp_d = ~half_i;
      arm_d = (half_i != '0);
      sq_d  = 1'b1;
    end else if (rise_i || tmo_hit_i || hit) begin
      arm_d = 1'b0;
      sq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      arm_q <= 1'b0;
      sq_q  <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      arm_q <= arm_d;
      sq_q  <= sq_d;
    end
  end

  assign sq_o = sq_q;

  AST_FALL_AT_MIDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sq_q) && !$past(rise_i) && !$past(tmo_hit_i)) |-> (cnt_i == cmp_q)); // R6

  AST_CMP_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld_i |=> $stable(cmp_q)); // R8
endmodule

// File: rtl/period_regen.sv
module period_regen
  import rgn_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MID     = 4,
  parameter int DIV_SLOW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       psc_sel_i,
  input  logic             sig_i,
  output logic             sq_o,
  output logic [CNT_W-1:0] period_o,
  output logic             timeout_o
);
  logic             tick, rise, cap_vld, tmo_hit;
  logic [CNT_W-1:0] cnt, half;

  rgn_prescale #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_psc (
    .clk(clk), .rst_n(rst_n), .sel_i(psc_sel_i), .tick_o(tick)
  );

  rgn_edge_det #(.SYNC(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .rise_o(rise)
  );

  rgn_period_timer #(.CW(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rise_i(rise),
    .cnt_o(cnt), .half_o(half), .cap_vld_o(cap_vld), .tmo_hit_o(tmo_hit),
    .timeout_o(timeout_o), .period_o(period_o)
  );

  rgn_duty_gen #(.CW(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rise_i(rise),
    .cap_vld_i(cap_vld), .tmo_hit_i(tmo_hit), .cnt_i(cnt), .half_i(half),
    .sq_o(sq_o)
  );

  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !sq_o); // R7

  AST_RISE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq_o) |-> $past(cap_vld)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!sq_o && period_o == '0 && !timeout_o)); // R1
endmodule

// File: tb/tb_period_regen.sv
`timescale 1ns/1ps
module tb_period_regen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  psc_sel;
  logic        sig;
  logic        sq_o;
  logic [15:0] period_o;
  logic        timeout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  period_regen dut (
    .clk(clk), .rst_n(rst_n), .psc_sel_i(psc_sel), .sig_i(sig),
    .sq_o(sq_o), .period_o(period_o), .timeout_o(timeout_o)
  );

  // {sel[7:0], high cycles[15:0], low cycles[15:0]}
  localparam logic [39:0] VEC [8] = '{
    {8'd1, 16'd3,   16'd7},
    {8'd1, 16'd20,  16'd13},
    {8'd1, 16'd1,   16'd1},
    {8'd1, 16'd7,   16'd2},
    {8'd1, 16'd100, 16'd100},
    {8'd2, 16'd10,  16'd30},
    {8'd2, 16'd3,   16'd5},
    {8'd3, 16'd32,  16'd96}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0;
    sig   = 1'b0;
    psc_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_period(input int hi, input int lo, output int nh);
    nh = 0;
    for (int i = 0; i < hi; i++) begin
      sig = 1'b1; @(negedge clk); if (sq_o) nh++;
    end
    for (int i = 0; i < lo; i++) begin
      sig = 1'b0; @(negedge clk); if (sq_o) nh++;
    end
  endtask

  function automatic int ratio_of(input int sel);
    if (sel == 1) return 1;
    if (sel == 2) return 4;
    return 16;
  endfunction

  initial begin
    int nh, sel, hi, lo, r, per, h;
    rst_n = 1'b0; sig = 1'b0; psc_sel = 2'b01;

    // R1: outputs during and after reset
    repeat (2) @(negedge clk);
    chk(sq_o == 1'b0, "R1 sq in reset", int'(sq_o), 0);
    do_reset(2'b01);
    chk(sq_o == 1'b0, "R1 sq after reset", int'(sq_o), 0);
    chk(period_o == 16'd0, "R1 period after reset", int'(period_o), 0);
    chk(timeout_o == 1'b0, "R1 timeout after reset", int'(timeout_o), 0);

    // Vector table: R2 / R4 period in ticks, R6 high time
    for (int v = 0; v < 8; v++) begin
      sel = int'(VEC[v][39:32]);
      hi  = int'(VEC[v][31:16]);
      lo  = int'(VEC[v][15:0]);
      r   = ratio_of(sel);
      per = (hi + lo) / r;
      h   = per / 2;
      do_reset(sel[1:0]);
      for (int k = 0; k < 4; k++) run_period(hi, lo, nh);
      run_period(hi, lo, nh);
      chk(int'(period_o) == per, "R4 R2 measured period", int'(period_o), per);
      chk_rng("R6 output high cycles", nh, (h - 1) * r + ((r == 1) ? 1 : 1) + ((r == 1) ? 0 : 0) - ((r == 1) ? 0 : 0) + ((r == 1) ? (h - (h - 1) - 1) : 0), h * r);
    end

    // R5: first edge after reset does not raise the output
    do_reset(2'b01);
    sig = 1'b1;
    repeat (10) @(negedge clk);
    chk(sq_o == 1'b0, "R5 no rise on first edge", int'(sq_o), 0);
    sig = 1'b0;
    repeat (10) @(negedge clk);
    run_period(10, 10, nh);
    chk(nh == 10, "R5 second edge raises output", nh, 10);
    chk(period_o == 16'd20, "R5 R4 period on second edge", int'(period_o), 20);

    // R3: duty change at constant period leaves results unchanged
    do_reset(2'b01);
    for (int k = 0; k < 4; k++) run_period(5, 15, nh);
    run_period(15, 5, nh);
    run_period(15, 5, nh);
    chk(period_o == 16'd20, "R3 period after duty change", int'(period_o), 20);
    chk(nh == 10, "R3 high time after duty change", nh, 10);

    // R2: tick select off means the counter never moves
    do_reset(2'b00);
    for (int k = 0; k < 6; k++) run_period(4, 4, nh);
    chk(period_o == 16'd0, "R2 period with ticks off", int'(period_o), 0);
    chk(timeout_o == 1'b0, "R2 no timeout with ticks off", int'(timeout_o), 0);

    // R7: timeout, recovery edge, then valid again
    do_reset(2'b01);
    for (int k = 0; k < 3; k++) run_period(10, 10, nh);
    sig = 1'b0;
    repeat (65600) @(negedge clk);
    chk(timeout_o == 1'b1, "R7 timeout raised", int'(timeout_o), 1);
    chk(sq_o == 1'b0, "R7 output low in timeout", int'(sq_o), 0);
    sig = 1'b1;
    repeat (5) @(negedge clk);
    chk(timeout_o == 1'b0, "R7 timeout cleared by edge", int'(timeout_o), 0);
    chk(sq_o == 1'b0, "R7 no rise on recovery edge", int'(sq_o), 0);
    chk(period_o == 16'd20, "R7 R8 period held over timeout", int'(period_o), 20);
    sig = 1'b0;
    repeat (15) @(negedge clk);
    run_period(10, 10, nh);
    chk(period_o == 16'd20, "R7 period after recovery", int'(period_o), 20);
    chk(nh == 10, "R7 output resumes", nh, 10);

    // R1: reset in the middle of activity
    run_period(3, 0, nh);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sq_o == 1'b0 && timeout_o == 1'b0, "R1 mid-run reset outputs", int'(sq_o), 0);
    chk(period_o == 16'd0, "R1 mid-run reset period", int'(period_o), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule